// File: doc/BRIEF.md
# Register-Mapped Factorial Accelerator

This peripheral sits behind a simple 32-bit register port (valid, write, address, byte size, write data) and computes the factorial of a number written by software. The engine runs a multi-cycle iterative loop; software watches a busy flag in the status word, or asks for a completion interrupt, and then reads the truncated result back from the operand location.

The block also provides a fixed identification word and a register that returns the one's complement of what was last written to it, for checking the bus path. A 32-bit interrupt status word can be set and cleared by software through two dedicated write-only locations, and it is also set by the engine on completion. A single level-sensitive interrupt output is high while any status bit is set. Read data is returned one cycle after the read request.

The engine is a two-state machine. In state IDLE it accepts an operand write (transition IDLE to RUN). In state RUN it performs one multiply per clock and counts the operand down. When the count reaches 1 or less it stores the product, pulses completion, and takes the transition RUN to IDLE. An operand write that arrives in RUN is dropped.

Top module: `fctl_accel`

## Requirements
- R1: A 4-byte read of offset 0x00 returns the constant 0x010000ED.
- R2: A 4-byte write to offset 0x04 stores the bitwise inverse of the written data, and a read of 0x04 returns that stored value.
- R3: A 4-byte write to offset 0x08 while not busy loads the operand and sets busy (status bit 0); the same write while busy is ignored and neither the operand nor the pending result changes.
- R4: On completion offset 0x08 holds n! truncated to 32 bits (0! = 1) and busy clears; busy is observed for n cycles after the write, and for one cycle when n is 0 or 1.
- R5: Status bit 7 at offset 0x20 is a read/write enable; when it is set at completion, interrupt status bit 0 is raised, and when it is clear no interrupt bit changes.
- R6: Offset 0x24 reads the interrupt status; a 4-byte write to 0x60 ORs the data into it and a 4-byte write to 0x64 clears the bits set in the data; a completion setting bit 0 in the same cycle as a software clear of bit 0 leaves bit 0 set.
- R7: The interrupt output is high exactly while the interrupt status word is nonzero; it changes in the same cycle as the status word.
- R8: A read of any size other than 4 bytes returns 0xFFFFFFFF; writes of any size other than 4 bytes have no effect.
- R9: A 4-byte read of an offset with no register returns zero.
- R10: After reset all registers, busy, the interrupt status and the interrupt output are zero.
- R11: A read response appears with the response valid flag exactly one cycle after the read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 8 | Byte offset of the access |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| irq_o | output | 1 | Level interrupt, high while interrupt status is nonzero |

## Verification
The two functions that can meet in one cycle are the engine's completion, which sets interrupt bit 0 when enabled, and a software write to the clear location that targets the same bit. The bench pre-sets bit 0, starts a 3-cycle computation with the enable on, and times a clear of bit 0 so that it is sampled on the very edge at which the engine finishes. It then reads the interrupt status and watches the interrupt line, expecting bit 0 still set and the line high, before clearing it again and seeing both drop.

// File: rtl/fctl_pkg.sv
package fctl_pkg;

    typedef enum logic {
        ENG_IDLE = 1'b0,
        ENG_RUN  = 1'b1
    } eng_state_e;

    localparam logic [7:0] OFF_IDENT   = 8'h00;
    localparam logic [7:0] OFF_INVERT  = 8'h04;
    localparam logic [7:0] OFF_OPERAND = 8'h08;
    localparam logic [7:0] OFF_STATUS  = 8'h20;
    localparam logic [7:0] OFF_ISTAT   = 8'h24;
    localparam logic [7:0] OFF_ISET    = 8'h60;
    localparam logic [7:0] OFF_ICLR    = 8'h64;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_IEN_BIT  = 7;

endpackage

// File: rtl/fctl_mul_engine.sv
module fctl_mul_engine
    import fctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] operand_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] value_o
);

    eng_state_e        state_q, state_d;
    logic [DATA_W-1:0] acc_q;
    logic [DATA_W-1:0] cnt_q;
    logic [DATA_W-1:0] value_q;
    logic [DATA_W-1:0] product;
    logic              last_step;

    assign last_step = (cnt_q <= DATA_W'(1));
    assign product   = acc_q * cnt_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENG_IDLE: if (start_i)   state_d = ENG_RUN;
            ENG_RUN:  if (last_step) state_d = ENG_IDLE;
            default:                 state_d = ENG_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ENG_IDLE;
        else        state_q <= state_d;
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            cnt_q   <= '0;
            value_q <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    if (start_i) begin
                        value_q <= operand_i;
                        cnt_q   <= operand_i;
                        acc_q   <= DATA_W'(1);
                    end
                end
                ENG_RUN: begin
                    if (last_step) begin
                        value_q <= acc_q;
                    end else begin
                        acc_q <= product;
                        cnt_q <= cnt_q - DATA_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy_o  = (state_q == ENG_RUN);
        done_o  = (state_q == ENG_RUN) && last_step;
        value_o = value_q;
    end

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R3
    AST_VALUE_HELD_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> $stable(value_o)); // R3
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> (cnt_q == $past(cnt_q) - DATA_W'(1))); // R4
    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o); // R4

endmodule

// File: rtl/fctl_irq_unit.sv
module fctl_irq_unit #(
    parameter int IRQ_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_we_i,
    input  logic             clr_we_i,
    input  logic [IRQ_W-1:0] mask_i,
    input  logic             hw_set_i,
    output logic [IRQ_W-1:0] stat_o,
    output logic             irq_o
);

    logic [IRQ_W-1:0] stat_q, stat_d;
    logic [IRQ_W-1:0] hw_vec;
    logic             irq_q;

    assign hw_vec = {{(IRQ_W-1){1'b0}}, hw_set_i};

    // Clear first, then sets: a set in the same cycle wins
    always_comb begin
        stat_d = stat_q;
        if (clr_we_i) stat_d = stat_d & ~mask_i;
        if (set_we_i) stat_d = stat_d | mask_i;
        stat_d = stat_d | hw_vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            irq_q  <= |stat_d;
        end
    end

    assign stat_o = stat_q;
    assign irq_o  = irq_q;

    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (stat_q != '0)); // R7
    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set_i |=> stat_q[0]); // R6
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && !set_we_i && !hw_set_i) |=> ((stat_q & $past(mask_i)) == '0)); // R6

endmodule

// File: rtl/fctl_accel.sv
module fctl_accel
    import fctl_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter int          ADDR_W   = 8,
    parameter int          SIZE_W   = 4,
    parameter logic [31:0] IDENT    = 32'h010000ED
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              irq_o
);

    localparam int          WORD_BYTES = DATA_W / 8;
    localparam logic [SIZE_W-1:0] FULL_SIZE = SIZE_W'(WORD_BYTES);

    logic              size_ok;
    logic              wr_ok;
    logic              rd_req;
    logic [DATA_W-1:0] inv_q;
    logic              ien_q;
    logic              eng_start;
    logic              eng_busy;
    logic              eng_done;
    logic [DATA_W-1:0] eng_value;
    logic              iset_we;
    logic              iclr_we;
    logic [DATA_W-1:0] istat;
    logic [DATA_W-1:0] rd_mux;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rsp_rdata_q;

    assign size_ok   = (req_size == FULL_SIZE);
    assign wr_ok     = req_valid && req_write && size_ok;
    assign rd_req    = req_valid && !req_write;
    assign eng_start = wr_ok && (req_addr == ADDR_W'(OFF_OPERAND)) && !eng_busy;
    assign iset_we   = wr_ok && (req_addr == ADDR_W'(OFF_ISET));
    assign iclr_we   = wr_ok && (req_addr == ADDR_W'(OFF_ICLR));

    // Plain registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inv_q <= '0;
            ien_q <= 1'b0;
        end else begin
            if (wr_ok && req_addr == ADDR_W'(OFF_INVERT)) inv_q <= ~req_wdata;
            if (wr_ok && req_addr == ADDR_W'(OFF_STATUS)) ien_q <= req_wdata[STAT_IEN_BIT];
        end
    end

    fctl_mul_engine #(.DATA_W(DATA_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (eng_start),
        .operand_i (req_wdata),
        .busy_o    (eng_busy),
        .done_o    (eng_done),
        .value_o   (eng_value)
    );

    fctl_irq_unit #(.IRQ_W(DATA_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we_i (iset_we),
        .clr_we_i (iclr_we),
        .mask_i   (req_wdata),
        .hw_set_i (eng_done && ien_q),
        .stat_o   (istat),
        .irq_o    (irq_o)
    );

    // Read decode
    always_comb begin
        rd_mux = '0;
        if (!size_ok) begin
            rd_mux = '1;
        end else begin
            unique case (req_addr)
                ADDR_W'(OFF_IDENT):   rd_mux = DATA_W'(IDENT);
                ADDR_W'(OFF_INVERT):  rd_mux = inv_q;
                ADDR_W'(OFF_OPERAND): rd_mux = eng_value;
                ADDR_W'(OFF_STATUS): begin
                    rd_mux[STAT_BUSY_BIT] = eng_busy;
                    rd_mux[STAT_IEN_BIT]  = ien_q;
                end
                ADDR_W'(OFF_ISTAT):   rd_mux = istat;
                default:              rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= rd_req;
            if (rd_req) rsp_rdata_q <= rd_mux;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rsp_valid); // R11
    AST_BAD_SIZE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !size_ok) |=> (rsp_rdata == '1)); // R8
    AST_IDENT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && size_ok && req_addr == ADDR_W'(OFF_IDENT)) |=> (rsp_rdata == DATA_W'(IDENT))); // R1

endmodule

// File: tb/tb_fctl_accel.sv
module tb_fctl_accel;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [3:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done_flag = 1'b0;

    always #2.5 clk = ~clk;

    fctl_accel dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops scoreboard on every response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++; n_fails++;
                $display("FAIL R11: actual unexpected response %h expected none", rsp_rdata);
            end else begin
                check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
            end
        end
    end

    // Driver tasks: called at a negedge, return at the next negedge
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] sz);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic [3:0] sz,
                          input logic [31:0] exp, input string tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R10 reset state
        check("R10 irq after reset", {31'b0, irq_o}, 32'h0);
        bus_rd(8'h20, 4'd4, 32'h0, "R10 status reset");
        bus_rd(8'h24, 4'd4, 32'h0, "R10 istat reset");
        bus_rd(8'h08, 4'd4, 32'h0, "R10 operand reset");
        bus_rd(8'h04, 4'd4, 32'h0, "R10 invert reset");
        // R1 identification, R11 back-to-back responses
        bus_rd(8'h00, 4'd4, 32'h010000ED, "R1 ident");
        bus_rd(8'h00, 4'd4, 32'h010000ED, "R11 ident back to back");
        // R2 inversion
        bus_wr(8'h04, 32'h12345678, 4'd4);
        bus_rd(8'h04, 4'd4, 32'hEDCBA987, "R2 invert");
        // R8 size rules
        bus_rd(8'h00, 4'd2, 32'hFFFFFFFF, "R8 read size 2");
        bus_rd(8'h04, 4'd8, 32'hFFFFFFFF, "R8 read size 8");
        bus_wr(8'h04, 32'h0, 4'd1);
        bus_rd(8'h04, 4'd4, 32'hEDCBA987, "R8 narrow write ignored");
        bus_wr(8'h08, 32'd7, 4'd2);
        bus_rd(8'h20, 4'd4, 32'h0, "R8 narrow operand write no busy");
        // R9 unmapped
        bus_rd(8'h40, 4'd4, 32'h0, "R9 unmapped 0x40");
        bus_rd(8'h90, 4'd4, 32'h0, "R9 unmapped 0x90");
        // R4 n=5: busy at k=5, clear at k=6
        bus_wr(8'h08, 32'd5, 4'd4);
        idle(4);
        bus_rd(8'h20, 4'd4, 32'h1, "R4 busy at cycle n");
        bus_rd(8'h20, 4'd4, 32'h0, "R4 idle at cycle n+1");
        bus_rd(8'h08, 4'd4, 32'd120, "R4 5 factorial");
        check("R5 no irq when disabled", {31'b0, irq_o}, 32'h0);
        bus_rd(8'h24, 4'd4, 32'h0, "R5 istat untouched when disabled");
        // R3 operand visible while busy, second write ignored
        bus_wr(8'h08, 32'd6, 4'd4);
        bus_rd(8'h08, 4'd4, 32'd6, "R3 operand while busy");
        bus_wr(8'h08, 32'd3, 4'd4);
        bus_rd(8'h20, 4'd4, 32'h1, "R3 busy set by start");
        idle(6);
        bus_rd(8'h08, 4'd4, 32'd720, "R3 write during busy ignored");
        // R4 zero and one
        bus_wr(8'h08, 32'd0, 4'd4);
        bus_rd(8'h20, 4'd4, 32'h1, "R4 busy one cycle for 0");
        bus_rd(8'h20, 4'd4, 32'h0, "R4 idle after 0");
        bus_rd(8'h08, 4'd4, 32'd1, "R4 0 factorial");
        bus_wr(8'h08, 32'd1, 4'd4);
        idle(2);
        bus_rd(8'h08, 4'd4, 32'd1, "R4 1 factorial");
        // R4 truncation
        bus_wr(8'h08, 32'd13, 4'd4);
        idle(14);
        bus_rd(8'h08, 4'd4, 32'd1932053504, "R4 13 factorial truncated");
        // R5 enable and completion interrupt
        bus_wr(8'h20, 32'h80, 4'd4);
        bus_rd(8'h20, 4'd4, 32'h80, "R5 enable readback");
        bus_wr(8'h08, 32'd4, 4'd4);
        idle(3);
        check("R7 irq low before completion", {31'b0, irq_o}, 32'h0);
        idle(1);
        check("R5 irq at completion", {31'b0, irq_o}, 32'h1);
        bus_rd(8'h24, 4'd4, 32'h1, "R5 istat bit0");
        bus_rd(8'h08, 4'd4, 32'd24, "R4 4 factorial");
        bus_wr(8'h64, 32'h1, 4'd4);
        check("R7 irq drops after clear", {31'b0, irq_o}, 32'h0);
        bus_rd(8'h24, 4'd4, 32'h0, "R6 clear bit0");
        // R6 software set/clear
        bus_wr(8'h60, 32'hF0, 4'd4);
        check("R7 irq from software set", {31'b0, irq_o}, 32'h1);
        bus_rd(8'h24, 4'd4, 32'hF0, "R6 set");
        bus_wr(8'h60, 32'h0, 2'd2);
        bus_wr(8'h64, 32'h30, 4'd4);
        bus_rd(8'h24, 4'd4, 32'hC0, "R6 partial clear");
        bus_wr(8'h64, 32'hC0, 4'd4);
        check("R7 irq low when all clear", {31'b0, irq_o}, 32'h0);
        // R6 completion and clear of bit0 on the same edge
        bus_wr(8'h60, 32'h1, 4'd4);
        bus_wr(8'h08, 32'd3, 4'd4);
        idle(2);
        bus_wr(8'h64, 32'h1, 4'd4);
        bus_rd(8'h24, 4'd4, 32'h1, "R6 completion wins over clear");
        check("R7 irq held after collision", {31'b0, irq_o}, 32'h1);
        bus_wr(8'h64, 32'h1, 4'd4);
        bus_rd(8'h24, 4'd4, 32'h0, "R6 clear after collision");
        check("R7 irq low at end", {31'b0, irq_o}, 32'h0);
        idle(3);
        if (exp_q.size() != 0) begin
            n_checks++; n_fails++;
            $display("FAIL R11: actual %0d missing responses expected 0", exp_q.size());
        end
        done_flag = 1'b1;
        summary();
        $finish;
    end

endmodule